// File: doc/BRIEF.md
# Protected Output Enable Controller

This block sits between a serial command interface and eight high-side output drivers. A command word is captured on a one-cycle strobe that marks a well-formed serial frame, and all eight driver enables switch together from that word. Protection logic sits on top of the command. A short to ground, held on an enabled channel for a debounce count of clock cycles, turns that channel off. An over-temperature flag turns all channels off and stays latched. A low powerdown input or a missing supply holds every output off for as long as it lasts.

For the serial read-back, the block also produces eight diagnostic bits. In normal operation each bit is the output level of its channel, registered once. While the thermal latch is set, each bit instead shows its fault polarity, which is the inverse of the stored command bit. A master can spot a thermal event because every bit disagrees with what it asked for.

Top module: `prot_out_ctrl`

## Requirements
- R1: On the clock edge where `frame_ok` is 1, `cmd_word` is stored. With no fault present, `drv_en` equals the stored word from the next cycle, and all eight bits change in the same cycle.
- R2: During and after reset, `drv_en` and `diag` are all zero.
- R3: A channel whose driver is enabled is turned off once `short_gnd` for that channel has been sampled 1 on DEB_CYCLES consecutive edges. Other channels are unaffected.
- R4: If `short_gnd` for a channel is sampled 0 before the count completes, the debounce count restarts from zero.
- R5: A channel turned off by a short stays off until the next `frame_ok` strobe. That frame rewrites the channel's bit and re-arms its short detection.
- R6: The edge that samples `over_temp` at 1 sets the thermal latch. From the next cycle, all of `drv_en` is 0.
- R7: While the thermal latch is set, `diag` equals the bitwise inverse of the stored command word. A channel commanded on therefore reads 0, and a channel commanded off reads 1.
- R8: The thermal latch clears only on a `frame_ok` strobe sampled while `over_temp` is 0. A strobe while `over_temp` is 1, or `over_temp` simply falling, leaves it set.
- R9: While `pd_n` is 0, `drv_en` is 0 in the same cycle, with no register in the path.
- R10: While `vdd_ok` or `vbat_ok` is 0, `drv_en` is 0 in the same cycle.
- R11: Outside thermal shutdown, `diag` equals `out_level` as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_word | input | CH | Command bits from the serial input register, 1 = driver on |
| frame_ok | input | 1 | One-cycle strobe: a frame with a bit count divisible by 8 has ended |
| short_gnd | input | CH | Per-channel short-to-ground indication |
| over_temp | input | 1 | Die above the thermal trip point |
| pd_n | input | 1 | Powerdown, active low |
| vdd_ok | input | 1 | Digital supply present |
| vbat_ok | input | 1 | Battery supply present |
| out_level | input | CH | Actual output level of each channel |
| drv_en | output | CH | Driver enables |
| diag | output | CH | Diagnostic bits for serial read-back |

## Verification
The hardest state to reach is a debounce count that has climbed to one short of its limit, been reset by a single low sample, and then climbed again. A counter that misses the restart would only show the error at the exact cycle of the limit. The bench therefore holds a channel's short input high for DEB_CYCLES-1 edges, drops it for one edge, and raises it again. It checks that the enable survives DEB_CYCLES-1 further edges and falls on the next one. The thermal release needs the same care. The bench sends a frame while still hot, then lets the temperature drop without a frame, and only then sends the releasing frame. Each of these three cases is checked on its own.

// File: rtl/poc_pkg.sv
package poc_pkg;

    typedef enum logic {
        TH_NORMAL  = 1'b0,
        TH_TRIPPED = 1'b1
    } therm_state_e;

    typedef struct packed {
        logic supply_ok;
        logic thermal_ok;
    } gate_t;

    function automatic logic supplies_ok(input logic pd_n, input logic vdd_ok,
                                         input logic vbat_ok);
        return pd_n & vdd_ok & vbat_ok;
    endfunction

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/poc_short_chan.sv
module poc_short_chan
    import poc_pkg::*;
#(
    parameter int DEB_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic enabled,
    input  logic short_in,
    input  logic rearm,
    output logic tripped
);
    localparam int CW = cnt_width(DEB_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            tripped <= 1'b0;
        end else if (rearm) begin
            cnt     <= '0;
            tripped <= 1'b0;
        end else if (enabled && short_in) begin
            if (cnt == LAST) begin
                cnt     <= '0;
                tripped <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt <= '0;
        end
    end
endmodule

// File: rtl/poc_therm_latch.sv
module poc_therm_latch
    import poc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         over_temp,
    input  logic         frame_ok,
    output therm_state_e state
);
    therm_state_e nxt;

    always_comb begin
        nxt = state;
        if (over_temp)
            nxt = TH_TRIPPED;
        else if (state == TH_TRIPPED && frame_ok)
            nxt = TH_NORMAL;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= TH_NORMAL;
        else     state <= nxt;
    end
endmodule

// File: rtl/prot_out_ctrl.sv
module prot_out_ctrl
    import poc_pkg::*;
#(
    parameter int CH         = 8,
    parameter int DEB_CYCLES = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CH-1:0] cmd_word,
    input  logic          frame_ok,
    input  logic [CH-1:0] short_gnd,
    input  logic          over_temp,
    input  logic          pd_n,
    input  logic          vdd_ok,
    input  logic          vbat_ok,
    input  logic [CH-1:0] out_level,
    output logic [CH-1:0] drv_en,
    output logic [CH-1:0] diag
);
    logic [CH-1:0] cmd_q;
    logic [CH-1:0] lvl_q;
    logic [CH-1:0] sc_off;
    therm_state_e  th_state;
    logic          therm_tripped;
    gate_t         gate;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            lvl_q <= '0;
        end else begin
            lvl_q <= out_level;
            if (frame_ok) cmd_q <= cmd_word;
        end
    end

    poc_therm_latch u_therm (
        .clk       (clk),
        .rst       (rst),
        .over_temp (over_temp),
        .frame_ok  (frame_ok),
        .state     (th_state)
    );

    assign therm_tripped   = (th_state == TH_TRIPPED);
    assign gate.supply_ok  = supplies_ok(pd_n, vdd_ok, vbat_ok);
    assign gate.thermal_ok = ~therm_tripped;

    for (genvar i = 0; i < CH; i++) begin : g_chan
        poc_short_chan #(.DEB_CYCLES(DEB_CYCLES)) u_sc (
            .clk      (clk),
            .rst      (rst),
            .enabled  (drv_en[i]),
            .short_in (short_gnd[i]),
            .rearm    (frame_ok),
            .tripped  (sc_off[i])
        );
    end

    assign drv_en = cmd_q & ~sc_off & {CH{gate.supply_ok & gate.thermal_ok}};
    assign diag   = therm_tripped ? ~cmd_q : lvl_q;
endmodule

// File: rtl/poc_checker.sv
module poc_checker #(
    parameter int CH = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [CH-1:0] cmd_word,
    input logic          frame_ok,
    input logic          over_temp,
    input logic          pd_n,
    input logic          vdd_ok,
    input logic          vbat_ok,
    input logic [CH-1:0] out_level,
    input logic [CH-1:0] drv_en,
    input logic [CH-1:0] diag,
    input logic [CH-1:0] cmd_q,
    input logic          tsd_q
);
    p_frame_applies_r1: assert property (@(posedge clk) disable iff (rst)
        (frame_ok && !over_temp && !tsd_q) |=>
        (!(pd_n && vdd_ok && vbat_ok) || drv_en == $past(cmd_word)));

    p_hot_all_off_r6: assert property (@(posedge clk) disable iff (rst)
        over_temp |=> (drv_en == '0));

    p_fault_polarity_r7: assert property (@(posedge clk) disable iff (rst)
        over_temp |=> ((diag ^ cmd_q) == {CH{1'b1}}));

    p_hot_holds_latch_r8: assert property (@(posedge clk) disable iff (rst)
        (tsd_q && over_temp) |=> tsd_q);

    p_powerdown_off_r9: assert property (@(posedge clk) disable iff (rst)
        !pd_n |-> (drv_en == '0));

    p_supply_off_r10: assert property (@(posedge clk) disable iff (rst)
        !(vdd_ok && vbat_ok) |-> (drv_en == '0));

    p_level_echo_r11: assert property (@(posedge clk) disable iff (rst)
        (!over_temp && !tsd_q) |=> (diag == $past(out_level)));
endmodule

bind prot_out_ctrl poc_checker #(.CH(CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_word  (cmd_word),
    .frame_ok  (frame_ok),
    .over_temp (over_temp),
    .pd_n      (pd_n),
    .vdd_ok    (vdd_ok),
    .vbat_ok   (vbat_ok),
    .out_level (out_level),
    .drv_en    (drv_en),
    .diag      (diag),
    .cmd_q     (cmd_q),
    .tsd_q     (therm_tripped)
);

// File: tb/prot_out_ctrl_test.sv
module prot_out_ctrl_test;
    localparam int CH  = 8;
    localparam int DEB = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CH-1:0] cmd_word = '0;
    logic          frame_ok = 1'b0;
    logic [CH-1:0] short_gnd = '0;
    logic          over_temp = 1'b0;
    logic          pd_n = 1'b1;
    logic          vdd_ok = 1'b1;
    logic          vbat_ok = 1'b1;
    logic [CH-1:0] out_level = '0;
    logic [CH-1:0] drv_en;
    logic [CH-1:0] diag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    prot_out_ctrl #(.CH(CH), .DEB_CYCLES(DEB)) uut (
        .clk(clk), .rst(rst), .cmd_word(cmd_word), .frame_ok(frame_ok),
        .short_gnd(short_gnd), .over_temp(over_temp), .pd_n(pd_n),
        .vdd_ok(vdd_ok), .vbat_ok(vbat_ok), .out_level(out_level),
        .drv_en(drv_en), .diag(diag)
    );

    task automatic chk(input string tag, input logic [CH-1:0] act,
                       input logic [CH-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic send(input logic [CH-1:0] w);
        cmd_word = w;
        frame_ok = 1'b1;
        tick();
        frame_ok = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        chk("R2 drv_en in reset", drv_en, '0);
        chk("R2 diag in reset", diag, '0);
        rst = 1'b0;
        tick();
        chk("R2 drv_en after reset", drv_en, '0);
        chk("R2 diag after reset", diag, '0);

        // R1 and R11: sweep every command word and a derived level pattern
        for (int w = 0; w < 256; w++) begin
            logic [CH-1:0] prev;
            prev      = drv_en;
            cmd_word  = CH'(w);
            frame_ok  = 1'b1;
            out_level = CH'(w) ^ 8'h5A;
            #1;
            chk("R1 held before edge", drv_en, prev);
            tick();
            frame_ok = 1'b0;
            chk("R1 word applied", drv_en, CH'(w));
            chk("R11 level echo", diag, CH'(w) ^ 8'h5A);
        end

        // R9, R10: combinational forcing
        send(8'hFF);
        pd_n = 1'b0; #1;
        chk("R9 powerdown", drv_en, 8'h00);
        pd_n = 1'b1; #1;
        chk("R9 powerdown released", drv_en, 8'hFF);
        vdd_ok = 1'b0; #1;
        chk("R10 vdd missing", drv_en, 8'h00);
        vdd_ok = 1'b1; vbat_ok = 1'b0; #1;
        chk("R10 vbat missing", drv_en, 8'h00);
        vbat_ok = 1'b1; #1;
        chk("R10 supplies back", drv_en, 8'hFF);

        // R3: debounce to the exact edge
        short_gnd = 8'h04;
        repeat (DEB - 1) tick();
        chk("R3 before limit", drv_en, 8'hFF);
        tick();
        chk("R3 channel off at limit", drv_en, 8'hFB);
        short_gnd = 8'h00;
        repeat (5) tick();
        chk("R5 stays off", drv_en, 8'hFB);
        send(8'hFF);
        chk("R5 frame re-enables", drv_en, 8'hFF);

        // R4: restart of the count
        short_gnd = 8'h20;
        repeat (DEB - 1) tick();
        short_gnd = 8'h00;
        tick();
        short_gnd = 8'h20;
        repeat (DEB - 1) tick();
        chk("R4 count restarted", drv_en, 8'hFF);
        tick();
        chk("R4 off after full count", drv_en, 8'hDF);
        short_gnd = 8'h00;
        send(8'hA5);
        chk("R5 new frame", drv_en, 8'hA5);

        // R6, R7: thermal trip
        out_level = 8'h0F;
        over_temp = 1'b1;
        #1;
        chk("R6 registered trip", drv_en, 8'hA5);
        tick();
        chk("R6 all off", drv_en, 8'h00);
        chk("R7 fault polarity", diag, 8'h5A);

        // R8: release rules
        send(8'h3C);
        chk("R8 frame while hot keeps off", drv_en, 8'h00);
        chk("R7 polarity follows new word", diag, 8'hC3);
        over_temp = 1'b0;
        repeat (3) tick();
        chk("R8 cooling alone keeps off", drv_en, 8'h00);
        chk("R7 still fault polarity", diag, 8'hC3);
        send(8'h3C);
        chk("R8 released by frame", drv_en, 8'h3C);
        chk("R11 level after release", diag, 8'h0F);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule